// File: doc/BRIEF.md
# Flash programming command controller

This block lets running firmware read, program and erase an on-chip, word-organised flash through a small register interface. Software loads a target byte address, a data word and a command code, then writes the start bit. Before touching the flash the controller checks the request against a set of protection rules. A request that breaks a rule leaves the flash untouched and raises a sticky fail flag. A legal program or erase holds the flash busy for a number of cycles set by the timing fields. When the operation completes, the start bit clears itself.

The flash array is a behavioural memory with an application region and a loader region, plus a small bank of configuration words. The byte address decodes as follows. Bits 31:22 must be zero. Bits 21:20 select the region: 00 is application, 01 is loader, 11 is configuration and 10 is unmapped. Bits 19:2 give the word offset within the region. An input tells the controller whether code is currently executing from the loader region. A separate unlock input stands in for the register write-protection sequence.

Top module: `flashCmdCtrl`

## Requirements
- R1: While control bit 0 (enable) is 0, a write of 1 to bit 0 of the trigger register (offset 0x10) is ignored: the trigger bit reads 0 and the flash is unchanged.
- R2: Control bit 1 (boot select) loads the inverse of `cfgBootBit` on `rstN`. It keeps its value across `sysRst`. It changes only through an unlocked control write.
- R3: A write to the control register (offset 0x0) takes effect only while `unlockIn` is 1, and this includes clearing the fail flag.
- R4: Register offsets: 0x0 control, 0x4 address, 0x8 data, 0xC command (bits 3:0 code, bits 5:4 stored), 0x10 trigger. Control layout: bit 0 enable, bit 1 boot select, bit 4 configuration update enable, bit 5 loader update enable, bit 6 fail, bits 10:8 program time PT, bits 14:12 erase time ET.
- R5: Command code 0x0 copies the addressed word into the data register. The trigger bit reads 1 for exactly one cycle after the trigger write.
- R6: Command code 0x1 writes the data register into the addressed word. The trigger bit reads 1 for (PT+1)*8+1 cycles after the trigger write.
- R7: Command code 0x2 writes all-ones across the 128-word page that holds the target, or across every configuration word. The trigger bit reads 1 for (ET+1)*64+1 cycles.
- R8: A program or erase fails in two cases: it targets the application region while `runLoader` is 0, or it targets the loader region while `runLoader` is 1.
- R9: A program or erase of the loader region from the application side fails unless control bit 5 is 1. A program or erase of the configuration words fails unless control bit 4 is 1.
- R10: Several conditions fail the operation: address bits 1:0 not 00, an offset beyond the region size, the unmapped region, any upper bit set, or a command code other than 0x0, 0x1 or 0x2. A failed operation changes no flash word and holds the trigger bit for one cycle.
- R11: The fail flag (control bit 6) is sticky. It clears only when an unlocked write to the control register carries 1 in bit 6.
- R12: While the trigger bit reads 1, writes to the control, address, data and command registers are ignored.
- R13: `sysRst` clears every register except boot select and leaves flash contents intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous full reset, active low |
| sysRst | input | 1 | Synchronous partial reset that keeps boot select |
| cfgBootBit | input | 1 | Configuration boot bit, inverted into boot select on full reset |
| unlockIn | input | 1 | Permits writes to the control register |
| runLoader | input | 1 | High while code executes from the loader region |
| busWr | input | 1 | Register write strobe |
| busAddr | input | 5 | Register byte offset |
| busWdata | input | 32 | Register write data |
| busRdata | output | 32 | Register read data for busAddr (combinational) |

## Verification
The assertions assume that `runLoader`, `cfgBootBit` and `unlockIn` change only between clock edges. They also assume that `sysRst` is a synchronous pulse, so that the stability checks can tie each register change to an unlocked write or to reset. The bench drives every input at the falling edge and raises `unlockIn` only around deliberate control writes. It never writes the trigger while an operation is running, except in the one case that checks the busy lockout. The bench sweeps every PT and ET value and the full matrix of region, command, execution side and update enables. Expected outcomes come from the requirement formulas.

// File: rtl/flashCmdPkg.sv
package flashCmdPkg;

  typedef enum logic [1:0] {
    RG_APP = 2'b00,
    RG_LDR = 2'b01,
    RG_BAD = 2'b10,
    RG_CFG = 2'b11
  } region_e;

  typedef struct packed {
    region_e region;
    logic    inRange;
    logic    aligned;
  } target_t;

  typedef struct packed {
    logic loadRead;
    logic doProgram;
    logic doErase;
    logic setFail;
    logic clearGo;
  } strobe_t;

  localparam logic [3:0] CMD_READ  = 4'h0;
  localparam logic [3:0] CMD_PROG  = 4'h1;
  localparam logic [3:0] CMD_ERASE = 4'h2;

  localparam logic [4:0] OFS_CTL  = 5'h00;
  localparam logic [4:0] OFS_ADDR = 5'h04;
  localparam logic [4:0] OFS_DATA = 5'h08;
  localparam logic [4:0] OFS_CMD  = 5'h0C;
  localparam logic [4:0] OFS_TRIG = 5'h10;

endpackage

// File: rtl/flashCmdControl.sv
module flashCmdControl
  import flashCmdPkg::*;
#(
  parameter int PROG_UNIT  = 8,
  parameter int ERASE_UNIT = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sysRst,
  input  logic       goBit,
  input  logic [3:0] cmdCode,
  input  target_t    tgt,
  input  logic       runLoader,
  input  logic       cfgUpdEn,
  input  logic       ldUpdEn,
  input  logic [2:0] ptSet,
  input  logic [2:0] etSet,
  output strobe_t    stb
);

  localparam int BIG_UNIT = (PROG_UNIT > ERASE_UNIT) ? PROG_UNIT : ERASE_UNIT;
  localparam int MAX_CYC  = 8 * BIG_UNIT;
  localparam int CNT_W    = $clog2(MAX_CYC);

  logic             busy;
  logic             opErase;
  logic [CNT_W-1:0] cnt;

  logic isRead, isWrite, badCmd, protFault, violation, start, finish;
  logic [CNT_W-1:0] progLast, eraseLast;

  always_comb begin
    isRead  = (cmdCode == CMD_READ);
    isWrite = (cmdCode == CMD_PROG) || (cmdCode == CMD_ERASE);
    badCmd  = !(isRead || isWrite);
    protFault = isWrite && (
                  ((tgt.region == RG_APP) && !runLoader) ||
                  ((tgt.region == RG_LDR) && (runLoader || !ldUpdEn)) ||
                  ((tgt.region == RG_CFG) && !cfgUpdEn));
    violation = badCmd || !tgt.aligned || !tgt.inRange || protFault;
    start     = goBit && !busy;
    finish    = busy && (cnt == '0);
    progLast  = CNT_W'((int'(ptSet) + 1) * PROG_UNIT - 1);
    eraseLast = CNT_W'((int'(etSet) + 1) * ERASE_UNIT - 1);
  end

  always_comb begin
    stb.setFail   = start && violation;
    stb.loadRead  = start && !violation && isRead;
    stb.doProgram = finish && !opErase;
    stb.doErase   = finish && opErase;
    stb.clearGo   = (start && (violation || isRead)) || finish;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      opErase <= 1'b0;
      cnt     <= '0;
    end else if (sysRst) begin
      busy    <= 1'b0;
      opErase <= 1'b0;
      cnt     <= '0;
    end else if (start && !violation && isWrite) begin
      busy    <= 1'b1;
      opErase <= (cmdCode == CMD_ERASE);
      cnt     <= (cmdCode == CMD_ERASE) ? eraseLast : progLast;
    end else if (finish) begin
      busy <= 1'b0;
    end else if (busy) begin
      cnt <= cnt - 1'b1;
    end
  end

  AST_BUSY_HOLDS_GO: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> goBit); // R6

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cnt != '0 && !sysRst) |=> (busy && cnt == $past(cnt) - 1'b1)); // R7

  AST_FAIL_NO_START: assert property (@(posedge clk) disable iff (!rstN)
    (stb.setFail && !sysRst) |=> !busy); // R10

endmodule

// File: rtl/flashCmdDatapath.sv
module flashCmdDatapath
  import flashCmdPkg::*;
#(
  parameter int APP_WORDS  = 256,
  parameter int LDR_WORDS  = 128,
  parameter int PAGE_WORDS = 128,
  parameter int CFG_WORDS  = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sysRst,
  input  logic        cfgBootBit,
  input  logic        unlockIn,
  input  logic        busWr,
  input  logic [4:0]  busAddr,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  input  strobe_t     stb,
  output logic        goBit,
  output logic [3:0]  cmdCode,
  output target_t     tgt,
  output logic        cfgUpdEn,
  output logic        ldUpdEn,
  output logic [2:0]  ptSet,
  output logic [2:0]  etSet
);

  localparam int ARR_WORDS = APP_WORDS + LDR_WORDS;
  localparam int IDX_W     = $clog2(ARR_WORDS);
  localparam int PAGE_W    = $clog2(PAGE_WORDS);
  localparam int CFG_IW    = (CFG_WORDS > 1) ? $clog2(CFG_WORDS) : 1;

  logic        ctlEnable, bootSel, ctlFail;
  logic [31:0] ispAddr, ispData;
  logic [5:0]  ispCmd;
  logic [31:0] cfgWord [CFG_WORDS];
  logic [31:0] mem [ARR_WORDS];

  logic [17:0]       wordOff;
  logic [IDX_W-1:0]  memIdx, pageBase;
  logic [CFG_IW-1:0] cfgIdx;
  logic [31:0]       readWord, ctlWord;
  logic              wrCtl, wrAddr, wrData, wrCmd, wrTrig;

  assign cmdCode = ispCmd[3:0];

  always_comb begin
    wordOff     = ispAddr[19:2];
    tgt.region  = region_e'(ispAddr[21:20]);
    tgt.aligned = (ispAddr[1:0] == 2'b00);
    case (tgt.region)
      RG_APP:  tgt.inRange = (wordOff < 18'(APP_WORDS));
      RG_LDR:  tgt.inRange = (wordOff < 18'(LDR_WORDS));
      RG_CFG:  tgt.inRange = (wordOff < 18'(CFG_WORDS));
      default: tgt.inRange = 1'b0;
    endcase
    if (ispAddr[31:22] != '0) tgt.inRange = 1'b0;
    memIdx   = (tgt.region == RG_LDR) ? IDX_W'(APP_WORDS) + wordOff[IDX_W-1:0]
                                      : wordOff[IDX_W-1:0];
    pageBase = {memIdx[IDX_W-1:PAGE_W], PAGE_W'(0)};
    cfgIdx   = wordOff[CFG_IW-1:0];
    if (tgt.region == RG_CFG) readWord = cfgWord[cfgIdx];
    else                      readWord = mem[memIdx];
  end

  always_comb begin
    wrCtl  = busWr && (busAddr == OFS_CTL)  && !goBit && unlockIn;
    wrAddr = busWr && (busAddr == OFS_ADDR) && !goBit;
    wrData = busWr && (busAddr == OFS_DATA) && !goBit;
    wrCmd  = busWr && (busAddr == OFS_CMD)  && !goBit;
    wrTrig = busWr && (busAddr == OFS_TRIG) && !goBit && ctlEnable && busWdata[0];
    ctlWord = {17'd0, etSet, 1'b0, ptSet, 1'b0, ctlFail, ldUpdEn, cfgUpdEn,
               2'b00, bootSel, ctlEnable};
    case (busAddr)
      OFS_CTL:  busRdata = ctlWord;
      OFS_ADDR: busRdata = ispAddr;
      OFS_DATA: busRdata = ispData;
      OFS_CMD:  busRdata = {26'd0, ispCmd};
      OFS_TRIG: busRdata = {31'd0, goBit};
      default:  busRdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      bootSel <= ~cfgBootBit;
    else if (wrCtl) bootSel <= busWdata[1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN || sysRst) begin
      ctlEnable <= 1'b0;
      cfgUpdEn  <= 1'b0;
      ldUpdEn   <= 1'b0;
      ctlFail   <= 1'b0;
      ptSet     <= '0;
      etSet     <= '0;
      ispAddr   <= '0;
      ispData   <= '0;
      ispCmd    <= '0;
      goBit     <= 1'b0;
    end else begin
      if (wrCtl) begin
        ctlEnable <= busWdata[0];
        cfgUpdEn  <= busWdata[4];
        ldUpdEn   <= busWdata[5];
        ptSet     <= busWdata[10:8];
        etSet     <= busWdata[14:12];
      end
      if (stb.setFail)                ctlFail <= 1'b1;
      else if (wrCtl && busWdata[6])  ctlFail <= 1'b0;
      if (wrAddr) ispAddr <= busWdata;
      if (wrCmd)  ispCmd  <= busWdata[5:0];
      if (stb.loadRead)  ispData <= readWord;
      else if (wrData)   ispData <= busWdata;
      if (stb.clearGo)   goBit <= 1'b0;
      else if (wrTrig)   goBit <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < CFG_WORDS; i++) cfgWord[i] <= '1;
    end else if (tgt.region == RG_CFG) begin
      if (stb.doProgram) cfgWord[cfgIdx] <= ispData;
      else if (stb.doErase)
        for (int i = 0; i < CFG_WORDS; i++) cfgWord[i] <= '1;
    end
  end

  always_ff @(posedge clk) begin
    if (tgt.region != RG_CFG) begin
      if (stb.doProgram) mem[memIdx] <= ispData;
      else if (stb.doErase)
        for (int i = 0; i < PAGE_WORDS; i++) mem[pageBase + IDX_W'(i)] <= '1;
    end
  end

  AST_DISABLED_NO_GO: assert property (@(posedge clk) disable iff (!rstN)
    (!ctlEnable && !goBit) |=> !goBit); // R1

  AST_BOOT_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    !unlockIn |=> $stable(bootSel)); // R2

  AST_LOCKED_CTL: assert property (@(posedge clk) disable iff (!rstN)
    (!unlockIn && !sysRst) |=> ($stable(ctlEnable) && $stable(ptSet) && $stable(etSet))); // R3

  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (ctlFail && !sysRst && !(busWr && unlockIn && busAddr == OFS_CTL && busWdata[6]))
      |=> ctlFail); // R11

  AST_BUSY_REGS_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (goBit && !sysRst) |=> ($stable(ispAddr) && $stable(ispCmd) && $stable(ldUpdEn))); // R12

  AST_FLASH_WRITE_UNDER_GO: assert property (@(posedge clk) disable iff (!rstN)
    (stb.doProgram || stb.doErase) |-> goBit); // R8

endmodule

// File: rtl/flashCmdCtrl.sv
module flashCmdCtrl
  import flashCmdPkg::*;
#(
  parameter int APP_WORDS  = 256,
  parameter int LDR_WORDS  = 128,
  parameter int PAGE_WORDS = 128,
  parameter int CFG_WORDS  = 2,
  parameter int PROG_UNIT  = 8,
  parameter int ERASE_UNIT = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sysRst,
  input  logic        cfgBootBit,
  input  logic        unlockIn,
  input  logic        runLoader,
  input  logic        busWr,
  input  logic [4:0]  busAddr,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata
);

  strobe_t    stb;
  target_t    tgt;
  logic       goBit, cfgUpdEn, ldUpdEn;
  logic [3:0] cmdCode;
  logic [2:0] ptSet, etSet;

  flashCmdDatapath #(
    .APP_WORDS(APP_WORDS), .LDR_WORDS(LDR_WORDS),
    .PAGE_WORDS(PAGE_WORDS), .CFG_WORDS(CFG_WORDS)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .sysRst(sysRst), .cfgBootBit(cfgBootBit),
    .unlockIn(unlockIn), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .stb(stb), .goBit(goBit),
    .cmdCode(cmdCode), .tgt(tgt), .cfgUpdEn(cfgUpdEn), .ldUpdEn(ldUpdEn),
    .ptSet(ptSet), .etSet(etSet)
  );

  flashCmdControl #(
    .PROG_UNIT(PROG_UNIT), .ERASE_UNIT(ERASE_UNIT)
  ) u_control (
    .clk(clk), .rstN(rstN), .sysRst(sysRst), .goBit(goBit),
    .cmdCode(cmdCode), .tgt(tgt), .runLoader(runLoader),
    .cfgUpdEn(cfgUpdEn), .ldUpdEn(ldUpdEn), .ptSet(ptSet), .etSet(etSet),
    .stb(stb)
  );

endmodule

// File: tb/flashCmdCtrl_bench.sv
module flashCmdCtrl_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sysRst = 1'b0;
  logic        cfgBootBit = 1'b0;
  logic        unlockIn = 1'b0;
  logic        runLoader = 1'b0;
  logic        busWr = 1'b0;
  logic [4:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;

  int vectors = 0;
  int miscompares = 0;
  logic [31:0] curCtl = 32'h1;

  flashCmdCtrl u_flashCmdCtrl (
    .clk(clk), .rstN(rstN), .sysRst(sysRst), .cfgBootBit(cfgBootBit),
    .unlockIn(unlockIn), .runLoader(runLoader), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata)
  );

  always #2 clk = ~clk;

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired (R6) act=hung exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  task automatic ctlSet(input logic [31:0] v);
    unlockIn = 1'b1;
    wr(5'h00, v);
    unlockIn = 1'b0;
  endtask

  task automatic runOp(input logic [3:0] cmd, input logic [31:0] addr, output int cycles);
    logic [31:0] g;
    wr(5'h04, addr);
    wr(5'h0C, {28'd0, cmd});
    wr(5'h10, 32'h1);
    cycles = 0;
    rd(5'h10, g);
    while (g[0]) begin
      cycles++;
      @(negedge clk);
      rd(5'h10, g);
    end
  endtask

  function automatic logic [31:0] failBit(input logic [31:0] ctl);
    return {31'd0, ctl[6]};
  endfunction

  initial begin
    logic [31:0] v;
    int cyc;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    rd(5'h00, v); chk("R2 reset boot select = ~cfgBootBit", v, 32'h2);
    rd(5'h04, v); chk("R4 reset address", v, 32'h0);
    rd(5'h10, v); chk("R4 reset trigger", v, 32'h0);

    wr(5'h10, 32'h1);
    rd(5'h10, v); chk("R1 trigger ignored while disabled", v, 32'h0);

    wr(5'h00, 32'h7731);
    rd(5'h00, v); chk("R3 locked control write ignored", v, 32'h2);

    curCtl = 32'h1;
    ctlSet(curCtl);
    rd(5'h00, v); chk("R3 unlocked control write", v, 32'h1);

    wr(5'h0C, 32'h35);
    rd(5'h0C, v); chk("R4 command bits 5:0 stored", v, 32'h35);

    // protection matrix, R8 and R9
    for (int rl = 0; rl < 2; rl++)
      for (int rg = 0; rg < 3; rg++)
        for (int c = 1; c < 3; c++)
          for (int ld = 0; ld < 2; ld++)
            for (int cf = 0; cf < 2; cf++) begin
              logic [31:0] a;
              logic expFail;
              runLoader = rl[0];
              curCtl = 32'h1 | (ld[0] ? 32'h20 : 32'h0) | (cf[0] ? 32'h10 : 32'h0);
              ctlSet(curCtl | 32'h40);
              a = (rg == 0) ? 32'h0000_0100 : (rg == 1) ? 32'h0010_0000 : 32'h0030_0000;
              expFail = (rg == 0) ? !rl[0] : (rg == 1) ? (rl[0] || !ld[0]) : !cf[0];
              runOp(c[3:0], a, cyc);
              rd(5'h00, v);
              chk(rg == 2 ? "R9 config gate" : (rg == 1 ? "R9 R8 loader gate" : "R8 app self-write"),
                  failBit(v), {31'd0, expFail});
              chk("R10 R6 R7 operation length", cyc,
                  expFail ? 1 : ((c == 1) ? 9 : 65));
            end

    // data path sweep from the loader side, application region writable
    runLoader = 1'b1;
    for (int et = 0; et < 8; et++) begin
      curCtl = 32'h1 | (et << 12);
      ctlSet(curCtl | 32'h40);
      runOp(4'h2, (et % 2) * 512 + 4 * (et * 5), cyc);
      chk("R7 erase length", cyc, (et + 1) * 64 + 1);
      runOp(4'h0, (et % 2) * 512 + 4 * 127, cyc);
      rd(5'h08, v); chk("R7 erased word reads ones", v, 32'hFFFF_FFFF);
    end
    for (int pt = 0; pt < 8; pt++) begin
      logic [31:0] d, a;
      d = 32'h1234_5678 ^ (pt * 32'h0101_0101);
      a = ((pt * 37) % 256) * 4;
      curCtl = 32'h1 | (pt << 8);
      ctlSet(curCtl);
      wr(5'h08, d);
      runOp(4'h1, a, cyc);
      chk("R6 program length", cyc, (pt + 1) * 8 + 1);
      wr(5'h08, 32'h0);
      runOp(4'h0, a, cyc);
      chk("R5 read length", cyc, 1);
      rd(5'h08, v); chk("R5 R6 readback", v, d);
    end

    // misaligned targets: word 0 holds pattern for pt=0
    for (int lo = 1; lo < 4; lo++) begin
      ctlSet(32'h1 | 32'h40);
      wr(5'h08, 32'hDEAD_0000 | lo);
      runOp(4'h1, lo, cyc);
      rd(5'h00, v); chk("R10 misaligned fails", failBit(v), 32'h1);
      chk("R10 fail length", cyc, 1);
      runOp(4'h0, 32'h0, cyc);
      rd(5'h08, v); chk("R10 misaligned leaves word", v, 32'h1234_5678);
    end
    for (int c = 3; c < 16; c++) begin
      ctlSet(32'h1 | 32'h40);
      runOp(c[3:0], 32'h0, cyc);
      rd(5'h00, v); chk("R10 bad command fails", failBit(v), 32'h1);
    end
    begin
      logic [31:0] badA [4];
      badA[0] = 32'h0000_0400; badA[1] = 32'h0020_0000;
      badA[2] = 32'h0040_0000; badA[3] = 32'h0030_0008;
      for (int k = 0; k < 4; k++) begin
        ctlSet(32'h1 | 32'h40);
        runOp(4'h0, badA[k], cyc);
        rd(5'h00, v); chk("R10 illegal target fails", failBit(v), 32'h1);
      end
    end

    // R11 sticky flag
    wr(5'h00, 32'h41);
    rd(5'h00, v); chk("R11 locked clear keeps fail", failBit(v), 32'h1);
    ctlSet(32'h1);
    rd(5'h00, v); chk("R11 write without bit 6 keeps fail", failBit(v), 32'h1);
    ctlSet(32'h41);
    rd(5'h00, v); chk("R11 unlocked w1c clears fail", failBit(v), 32'h0);

    // loader update from application side, and configuration words
    runLoader = 1'b0;
    ctlSet(32'h31);
    wr(5'h08, 32'hA5A5_0F0F);
    runOp(4'h1, 32'h0010_0010, cyc);
    runOp(4'h0, 32'h0010_0010, cyc);
    rd(5'h08, v); chk("R9 loader program with bit 5", v, 32'hA5A5_0F0F);
    wr(5'h08, 32'h0000_0055);
    runOp(4'h1, 32'h0030_0004, cyc);
    runOp(4'h0, 32'h0030_0004, cyc);
    rd(5'h08, v); chk("R9 config program with bit 4", v, 32'h0000_0055);
    runOp(4'h2, 32'h0030_0000, cyc);
    runOp(4'h0, 32'h0030_0004, cyc);
    rd(5'h08, v); chk("R7 config erase", v, 32'hFFFF_FFFF);

    // R12 busy lockout
    ctlSet(32'h1 | (7 << 8));
    runLoader = 1'b1;
    wr(5'h04, 32'h0000_0008);
    wr(5'h0C, 32'h1);
    wr(5'h10, 32'h1);
    wr(5'h04, 32'h0000_0044);
    unlockIn = 1'b1; wr(5'h00, 32'h0); unlockIn = 1'b0;
    rd(5'h04, v); chk("R12 address write ignored while busy", v, 32'h8);
    rd(5'h00, v); chk("R12 control write ignored while busy", v, 32'h0000_0701);
    repeat (80) @(negedge clk);
    rd(5'h10, v); chk("R12 operation completes", v, 32'h0);

    // R13 partial reset keeps boot select
    ctlSet(32'h1);
    @(negedge clk); sysRst = 1'b1;
    @(negedge clk); sysRst = 1'b0;
    rd(5'h00, v); chk("R13 R2 sysRst keeps boot select 0", v, 32'h0);
    rd(5'h04, v); chk("R13 sysRst clears address", v, 32'h0);
    ctlSet(32'h1);
    runOp(4'h0, 32'h0010_0010, cyc);
    rd(5'h08, v); chk("R13 flash survives sysRst", v, 32'hA5A5_0F0F);

    cfgBootBit = 1'b1;
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    rd(5'h00, v); chk("R2 full reset loads inverse of 1", v, 32'h0);
    ctlSet(32'h2);
    rd(5'h00, v); chk("R2 unlocked boot select write", v, 32'h2);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule